// File: doc/BRIEF.md
# Configuration Readback Command Sequencer

This block runs one complete readback of an FPGA's configuration through the device's internal configuration access port. On a start request it writes a fixed list of twenty setup command words into the port's byte-wide input. Those words include one that sets the first frame to read and one that sets how many bytes the port should return. The block then raises a read strobe and accepts exactly that many returned bytes. It ignores any further bytes the port offers.

Each accepted byte is forwarded downstream one cycle later. The byte carries a valid flag, a start-of-frame flag and the index of the frame it belongs to, so that a hashing or masking stage can work frame by frame. After the last byte is captured, the block writes six shutdown command words. It then pulses done and returns to idle.

The command words are held in an on-chip ROM. The start frame address and the readback byte count are parameters, and they are patched into their two table slots when the design is elaborated. The configuration port is outside the block and the testbench models it.

Top module: `cfgrb_sequencer`

## Requirements
- R1: While rst is high and in the cycle after it, busy, done, cmd_wr, cmd_ce, out_valid and out_sof are low, and cmd_data, out_data and out_frame are zero.
- R2: The command table holds 26 words, numbered 0 to 25. Each word is sent as 4 bytes, most significant byte first, so byte n of the stream is byte (3 - n mod 4) of word n/4. Word 17 equals FRAME_ADDR. Word 19 equals RB_BYTES as a 32-bit value. Every other word k equals {8'hA5, k[7:0], 8'h5A, ~k[7:0]}.
- R3: After start is sampled high in idle, the 80 bytes of words 0 to 19 appear on cmd_data on 80 consecutive cycles, beginning one cycle after busy rises. During these cycles cmd_wr and cmd_ce are both high, and cmd_wr never rises without cmd_ce. cmd_data is zero whenever cmd_wr is low.
- R4: Exactly one cycle with both cmd_wr and cmd_ce low separates the last setup byte from the read strobe. The read strobe is cmd_ce high with cmd_wr low.
- R5: A byte is accepted when rb_vld is sampled high while the read strobe is high. Exactly RB_BYTES bytes are accepted. The read strobe falls at the edge that accepts the last byte.
- R6: Each accepted byte appears on out_data with out_valid high in the following cycle, in the order it was accepted. In all other cycles out_valid is low and out_data is zero.
- R7: Bytes are grouped into frames of FRAME_BYTES bytes. out_sof is high with the first byte of each frame, including a short final frame. out_frame gives the frame index, starting at 0, and is zero when out_valid is low.
- R8: A high rb_vld while the read strobe is low produces no output and does not count toward RB_BYTES.
- R9: One cycle with both strobes low follows the read strobe. The 24 bytes of words 20 to 25 are then written on consecutive cycles, with cmd_wr and cmd_ce high.
- R10: done is high for exactly one cycle, in the cycle after the last shutdown byte. busy falls in that same cycle, and busy stays high from one cycle after start until then.
- R11: start is ignored while busy is high. The sequence in progress is neither restarted nor lengthened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one readback, sampled in idle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_data | output | 8 | Command byte to the port input |
| cmd_wr | output | 1 | Write strobe for cmd_data |
| cmd_ce | output | 1 | Port enable; high without cmd_wr is the read strobe |
| rb_data | input | 8 | Byte returned by the port |
| rb_vld | input | 1 | rb_data holds a byte |
| out_data | output | 8 | Forwarded configuration byte |
| out_valid | output | 1 | out_data is valid |
| out_sof | output | 1 | First byte of a frame |
| out_frame | output | FRM_W | Frame index of out_data |

## Verification
The bench builds the block with FRAME_ADDR = 32'h0012_3400, RB_BYTES = 40 and FRAME_BYTES = 12. With these values the patched words are easy to recognise in the command stream, and the last frame is a short one of four bytes. The whole sequence also stays short enough to run it three times. The runs use a port that returns a byte every cycle, one that returns bytes on about three cycles in four, and one that returns bytes on about one cycle in four. The port also offers bytes outside the read strobe and after the count is reached. One run repeats the start request while the block is busy.

// File: rtl/cfgrb_pkg.sv
`timescale 1ns/1ps
package cfgrb_pkg;

  localparam int unsigned WORD_BYTES  = 4;
  localparam int unsigned SETUP_WORDS = 20;
  localparam int unsigned SHUT_WORDS  = 6;
  localparam int unsigned SETUP_BYTES = SETUP_WORDS * WORD_BYTES;
  localparam int unsigned TOTAL_BYTES = (SETUP_WORDS + SHUT_WORDS) * WORD_BYTES;

  // Table slots whose contents come from parameters.
  localparam logic [7:0] SLOT_START_FRAME = 8'd17;
  localparam logic [7:0] SLOT_BYTE_COUNT  = 8'd19;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_GAP,
    ST_CAPTURE,
    ST_SHUT,
    ST_FINISH
  } seq_state_t;

  function automatic logic [31:0] cmd_word(input logic [7:0]  slot,
                                           input logic [31:0] start_frame,
                                           input logic [31:0] byte_count);
    logic [31:0] w;
    if (slot == SLOT_START_FRAME)     w = start_frame;
    else if (slot == SLOT_BYTE_COUNT) w = byte_count;
    else                              w = {8'hA5, slot, 8'h5A, ~slot};
    return w;
  endfunction

  // Byte n of the command stream; words go out most significant byte first.
  function automatic logic [7:0] cmd_byte(input logic [7:0]  idx,
                                          input logic [31:0] start_frame,
                                          input logic [31:0] byte_count);
    logic [31:0] w;
    logic [7:0]  b;
    w = cmd_word({2'b00, idx[7:2]}, start_frame, byte_count);
    case (idx[1:0])
      2'd0:    b = w[31:24];
      2'd1:    b = w[23:16];
      2'd2:    b = w[15:8];
      default: b = w[7:0];
    endcase
    return b;
  endfunction

endpackage

// File: rtl/cfgrb_cmd_rom.sv
`timescale 1ns/1ps
module cfgrb_cmd_rom
  import cfgrb_pkg::*;
#(
  parameter logic [31:0] FRAME_ADDR = 32'h0,
  parameter int unsigned RB_BYTES   = 4096,
  parameter int unsigned ADDR_W     = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        q
);

  localparam logic [31:0] COUNT_WORD = 32'(RB_BYTES);

  // Synchronous read with synchronous output clear: maps onto a block RAM
  // used as a ROM, and keeps the byte bus at zero outside write phases.
  always_ff @(posedge clk) begin
    if (rst || !en) q <= 8'h00;
    else            q <= cmd_byte(8'(addr), FRAME_ADDR, COUNT_WORD);
  end

endmodule

// File: rtl/cfgrb_frame_tracker.sv
`timescale 1ns/1ps
module cfgrb_frame_tracker #(
  parameter int unsigned FRAME_BYTES = 164,
  parameter int unsigned FRM_W       = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             accept,
  input  logic [7:0]       din,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic [FRM_W-1:0] out_frame
);

  localparam int unsigned POS_W = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BYTES - 1);

  logic [POS_W-1:0] pos;
  logic [FRM_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= 8'h00;
      out_sof   <= 1'b0;
      out_frame <= '0;
      pos       <= '0;
      idx       <= '0;
    end else begin
      out_valid <= accept;
      out_data  <= accept ? din : 8'h00;
      out_sof   <= accept && (pos == '0);
      out_frame <= accept ? idx : '0;
      if (clear) begin
        pos <= '0;
        idx <= '0;
      end else if (accept) begin
        if (pos == LAST_POS) begin
          pos <= '0;
          idx <= idx + 1'b1;
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cfgrb_ctrl.sv
`timescale 1ns/1ps
module cfgrb_ctrl
  import cfgrb_pkg::*;
#(
  parameter int unsigned RB_BYTES = 4096,
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned CNT_W    = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rb_vld,
  output logic              busy,
  output logic              done,
  output logic              cmd_wr,
  output logic              cmd_ce,
  output logic              rom_en,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              accept,
  output logic              trk_clear
);

  localparam logic [ADDR_W-1:0] LAST_SETUP = ADDR_W'(SETUP_BYTES - 1);
  localparam logic [ADDR_W-1:0] LAST_SHUT  = ADDR_W'(TOTAL_BYTES - 1);
  localparam logic [CNT_W-1:0]  LAST_GOT   = CNT_W'(RB_BYTES - 1);

  seq_state_t        state;
  logic [ADDR_W-1:0] ptr;
  logic [CNT_W-1:0]  got;

  assign rom_en    = (state == ST_SETUP) || (state == ST_SHUT);
  assign rom_addr  = ptr;
  assign accept    = (state == ST_CAPTURE) && cmd_ce && !cmd_wr && rb_vld;
  assign trk_clear = (state == ST_GAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      ptr    <= '0;
      got    <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      cmd_wr <= 1'b0;
      cmd_ce <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          cmd_wr <= 1'b0;
          cmd_ce <= 1'b0;
          if (start) begin
            state <= ST_SETUP;
            busy  <= 1'b1;
            ptr   <= '0;
          end
        end
        ST_SETUP: begin
          cmd_wr <= 1'b1;
          cmd_ce <= 1'b1;
          ptr    <= ptr + 1'b1;
          if (ptr == LAST_SETUP) state <= ST_GAP;
        end
        ST_GAP: begin
          cmd_wr <= 1'b0;
          cmd_ce <= 1'b0;
          got    <= '0;
          state  <= ST_CAPTURE;
        end
        ST_CAPTURE: begin
          cmd_wr <= 1'b0;
          if (accept) got <= got + 1'b1;
          if (accept && (got == LAST_GOT)) begin
            cmd_ce <= 1'b0;
            state  <= ST_SHUT;
          end else begin
            cmd_ce <= 1'b1;
          end
        end
        ST_SHUT: begin
          cmd_wr <= 1'b1;
          cmd_ce <= 1'b1;
          ptr    <= ptr + 1'b1;
          if (ptr == LAST_SHUT) state <= ST_FINISH;
        end
        ST_FINISH: begin
          cmd_wr <= 1'b0;
          cmd_ce <= 1'b0;
          done   <= 1'b1;
          busy   <= 1'b0;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfgrb_sequencer.sv
`timescale 1ns/1ps
module cfgrb_sequencer
  import cfgrb_pkg::*;
#(
  parameter logic [31:0] FRAME_ADDR  = 32'h0000_0000,
  parameter int unsigned RB_BYTES    = 4096,
  parameter int unsigned FRAME_BYTES = 164,
  localparam int unsigned NFRM  = (RB_BYTES + FRAME_BYTES - 1) / FRAME_BYTES,
  localparam int unsigned FRM_W = (NFRM > 1) ? $clog2(NFRM) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [7:0]       cmd_data,
  output logic             cmd_wr,
  output logic             cmd_ce,
  input  logic [7:0]       rb_data,
  input  logic             rb_vld,
  output logic [7:0]       out_data,
  output logic             out_valid,
  output logic             out_sof,
  output logic [FRM_W-1:0] out_frame
);

  localparam int unsigned ADDR_W = $clog2(TOTAL_BYTES);
  localparam int unsigned CNT_W  = $clog2(RB_BYTES + 1);

  logic              rom_en;
  logic [ADDR_W-1:0] rom_addr;
  logic              accept;
  logic              trk_clear;

  cfgrb_ctrl #(
    .RB_BYTES (RB_BYTES),
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .rb_vld    (rb_vld),
    .busy      (busy),
    .done      (done),
    .cmd_wr    (cmd_wr),
    .cmd_ce    (cmd_ce),
    .rom_en    (rom_en),
    .rom_addr  (rom_addr),
    .accept    (accept),
    .trk_clear (trk_clear)
  );

  cfgrb_cmd_rom #(
    .FRAME_ADDR (FRAME_ADDR),
    .RB_BYTES   (RB_BYTES),
    .ADDR_W     (ADDR_W)
  ) u_rom (
    .clk  (clk),
    .rst  (rst),
    .en   (rom_en),
    .addr (rom_addr),
    .q    (cmd_data)
  );

  cfgrb_frame_tracker #(
    .FRAME_BYTES (FRAME_BYTES),
    .FRM_W       (FRM_W)
  ) u_frames (
    .clk       (clk),
    .rst       (rst),
    .clear     (trk_clear),
    .accept    (accept),
    .din       (rb_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sof   (out_sof),
    .out_frame (out_frame)
  );

endmodule

// File: rtl/cfgrb_sequencer_chk.sv
`timescale 1ns/1ps
module cfgrb_sequencer_chk #(
  parameter int unsigned RB_BYTES = 4096
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic cmd_wr,
  input logic cmd_ce,
  input logic rb_vld,
  input logic out_valid,
  input logic out_sof
);

  logic [31:0] beats;

  always_ff @(posedge clk) begin
    if (rst || !busy) beats <= 32'd0;
    else if (out_valid) beats <= beats + 32'd1;
  end

  // R3: a write always carries the enable
  a_r3_wr_needs_ce: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |-> cmd_ce);

  // R4: a write is never followed directly by the read strobe
  a_r4_gap_before_read: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |=> !(cmd_ce && !cmd_wr));

  // R9: the read strobe is never followed directly by a write
  a_r9_gap_after_read: assert property (@(posedge clk) disable iff (rst)
    (cmd_ce && !cmd_wr) |=> !cmd_wr);

  // R5: no beat beyond the programmed count within one run
  a_r5_no_excess: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (beats < RB_BYTES));

  // R8: forwarded bytes only come from bytes offered under the read strobe
  a_r8_valid_from_strobe: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(cmd_ce && !cmd_wr && rb_vld));

  // R7: a frame marker only accompanies a valid byte
  a_r7_sof_with_valid: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid);

  // R10: done is a single pulse that ends busy
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R10: strobes stay quiet outside a sequence
  a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!cmd_wr && !cmd_ce));

  // R11: a start during a sequence does not end it
  a_r11_start_while_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !cmd_wr && !cmd_ce && !done && $past(busy)) |=> (busy || done));

endmodule

bind cfgrb_sequencer cfgrb_sequencer_chk #(.RB_BYTES(RB_BYTES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .cmd_wr    (cmd_wr),
  .cmd_ce    (cmd_ce),
  .rb_vld    (rb_vld),
  .out_valid (out_valid),
  .out_sof   (out_sof)
);

// File: tb/tb_cfgrb_sequencer.sv
`timescale 1ns/1ps
module tb_cfgrb_sequencer;

  localparam logic [31:0] P_FAR = 32'h0012_3400;
  localparam int P_LEN  = 40;
  localparam int P_FB   = 12;
  localparam int P_NFRM = (P_LEN + P_FB - 1) / P_FB;
  localparam int P_FW   = (P_NFRM > 1) ? $clog2(P_NFRM) : 1;
  localparam int SET_N  = 80;
  localparam int ALL_N  = 104;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic            busy, done, cmd_wr, cmd_ce, out_valid, out_sof;
  logic [7:0]      cmd_data, out_data;
  logic [7:0]      rb_data = 8'h00;
  logic            rb_vld = 1'b0;
  logic [P_FW-1:0] out_frame;

  cfgrb_sequencer #(.FRAME_ADDR(P_FAR), .RB_BYTES(P_LEN), .FRAME_BYTES(P_FB)) dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .cmd_data(cmd_data), .cmd_wr(cmd_wr), .cmd_ce(cmd_ce),
    .rb_data(rb_data), .rb_vld(rb_vld),
    .out_data(out_data), .out_valid(out_valid), .out_sof(out_sof), .out_frame(out_frame)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int mode = 0;
  bit checking = 0;
  int n_out, n_sof, n_wr, n_done;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // R2 table, written from the requirement
  function automatic logic [7:0] spec_byte(input int idx);
    int slot;
    logic [31:0] w;
    slot = idx / 4;
    if (slot == 17)      w = P_FAR;
    else if (slot == 19) w = 32'(P_LEN);
    else                 w = {8'hA5, 8'(slot), 8'h5A, ~8'(slot)};
    return 8'(w >> (8 * (3 - (idx % 4))));
  endfunction

  // Behavioural reference: phase 0 idle, 1 setup, 2 gap, 3 capture, 4 shutdown, 5 finish
  int   m_ph, m_ptr, m_cnt, m_fpos, m_fidx;
  logic m_busy, m_done, m_wr, m_ce, m_ov, m_sof, m_prev_rd;
  logic [7:0] m_data, m_od;
  int   m_frm;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_ptr = 0; m_cnt = 0; m_fpos = 0; m_fidx = 0;
      m_busy = 0; m_done = 0; m_wr = 0; m_ce = 0; m_ov = 0; m_sof = 0;
      m_data = 0; m_od = 0; m_frm = 0; m_prev_rd = 0;
    end else begin
      logic acc;
      m_prev_rd = m_ce && !m_wr;
      acc = (m_ph == 3) && m_prev_rd && rb_vld;
      m_ov  = acc;
      m_od  = acc ? rb_data : 8'h00;
      m_sof = acc && (m_fpos == 0);
      m_frm = acc ? m_fidx : 0;
      if (acc) begin
        m_fpos++;
        if (m_fpos == P_FB) begin m_fpos = 0; m_fidx++; end
      end
      m_done = 0;
      case (m_ph)
        0: begin
          m_wr = 0; m_ce = 0; m_data = 0;
          if (start) begin m_ph = 1; m_busy = 1; m_ptr = 0; end
        end
        1: begin
          m_wr = 1; m_ce = 1; m_data = spec_byte(m_ptr); m_ptr++;
          if (m_ptr == SET_N) m_ph = 2;
        end
        2: begin
          m_wr = 0; m_ce = 0; m_data = 0; m_cnt = 0; m_fpos = 0; m_fidx = 0; m_ph = 3;
        end
        3: begin
          m_wr = 0; m_data = 0;
          if (acc) m_cnt++;
          if (acc && m_cnt == P_LEN) begin m_ce = 0; m_ph = 4; end
          else m_ce = 1;
        end
        4: begin
          m_wr = 1; m_ce = 1; m_data = spec_byte(m_ptr); m_ptr++;
          if (m_ptr == ALL_N) m_ph = 5;
        end
        default: begin
          m_wr = 0; m_ce = 0; m_data = 0; m_done = 1; m_busy = 0; m_ph = 0;
        end
      endcase
    end
  end

  // Compare every cycle, then drive the port model for the next edge
  always @(negedge clk) begin
    if (!rst && checking) begin
      string ctag;
      ctag = m_wr ? ((m_ptr <= SET_N) ? "R3" : "R9") : "R4";
      chk(ctag, "cmd_wr", cmd_wr, m_wr);
      chk(ctag, "cmd_ce", cmd_ce, m_ce);
      chk("R2", "cmd_data", cmd_data, m_data);
      chk("R10", "busy", busy, m_busy);
      chk("R10", "done", done, m_done);
      chk("R6", "out_valid", out_valid, m_ov);
      chk("R6", "out_data", out_data, m_od);
      chk("R7", "out_sof", out_sof, m_sof);
      chk("R7", "out_frame", out_frame, m_frm);
      if (!m_prev_rd) chk("R8", "out_valid without read strobe", out_valid, 0);
      if (out_valid) n_out++;
      if (out_sof)   n_sof++;
      if (cmd_wr)    n_wr++;
      if (done)      n_done++;
    end
    case (mode)
      0:       rb_vld = 1'b1;
      1:       rb_vld = ($urandom % 4) != 0;
      default: rb_vld = ($urandom % 4) == 0;
    endcase
    rb_data = 8'($urandom);
  end

  task automatic run(input int md, input bit poke);
    int guard;
    mode = md;
    n_out = 0; n_sof = 0; n_wr = 0; n_done = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      // R11: second start in mid-sequence
      repeat (30) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (70) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    guard = 0;
    while (n_done == 0 && guard < 3000) begin @(negedge clk); guard++; end
    repeat (4) @(negedge clk);
    chk("R10", "run completed", n_done, 1);
    chk("R5", "bytes forwarded", n_out, P_LEN);
    chk("R7", "frame starts", n_sof, P_NFRM);
    chk("R3", "command bytes written", n_wr, ALL_N);
    if (poke) chk("R11", "done pulses with extra start", n_done, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "done in reset", done, 0);
    chk("R1", "cmd_wr in reset", cmd_wr, 0);
    chk("R1", "cmd_ce in reset", cmd_ce, 0);
    chk("R1", "cmd_data in reset", cmd_data, 0);
    chk("R1", "out_valid in reset", out_valid, 0);
    chk("R1", "out_sof in reset", out_sof, 0);
    chk("R1", "out_frame in reset", out_frame, 0);
    rst = 1'b0;
    checking = 1;
    repeat (5) @(negedge clk);
    run(0, 1'b0);
    run(1, 1'b1);
    run(2, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule